// File: doc/BRIEF.md
# Three-Wire Addressed Register Loader

This block is the programming port of a frequency synthesizer. A host drives three wires: a serial clock, a serial data line and an active-low frame enable. While the frame enable is low, each rising edge of the serial clock shifts one data bit into a 21-bit shift register. When the enable returns high, the four most recently shifted bits are taken as an address. The seventeen bits shifted before them are then written into one of four holding registers: a test word, a control word, the main divider coefficient or the reference divider coefficient.

The block runs on the chip's own clock. The three bus wires are resynchronised and edge-detected, so the serial clock may be slow and need not be related to the core clock. The outputs are the latched divider coefficients, the lock-detect enable, the charge-pump current select, the current multiple that this select stands for, and the combined power state. The power state is on only when the power-on pin is high and the software power bit is set. The port keeps accepting words while the synthesizer is off.

Top module: `tlw_loader`

## Requirements
- R1: After reset every holding register is zero, so main_div, ref_div, test_word, lock_det_en, cp_sel and soft_pon read 0, cp_mult reads 10 and synth_on reads 0.
- R2: Serial clock edges that occur while ser_en_n is high leave the shift register unchanged.
- R3: Only the last 21 bits shifted in a frame are kept. Any earlier bits in the same frame have no effect, and the number of clock pulses is not checked.
- R4: Bits are sent MSB first. The first 17 bits form the data field (bit 16 first), and the last 4 bits form the address (bit 3 first). Address 4'b0100 loads all 17 data bits into main_div.
- R5: Address 4'b0101 loads data bits 10..0 into ref_div. Data bits 16..11 are discarded.
- R6: Address 4'b0001 loads the control word. Data bit 12 drives lock_det_en, data bits 10..9 drive cp_sel[1:0], and data bit 6 drives soft_pon.
- R7: cp_mult follows cp_sel: code 0 gives 10, code 1 gives 18, code 2 gives 13 and code 3 gives 17.
- R8: Address 4'b0000 loads all 17 data bits into test_word.
- R9: Each of the other twelve address codes leaves every holding register unchanged. A word sent to a valid address changes only its own register.
- R10: A holding register changes only after ser_en_n rises. After the last bit is shifted, the register keeps its old value for as long as the enable stays low.
- R11: Words load whatever the level of pwr_on. synth_on is high exactly when pwr_on is high and soft_pon is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bus clock; data is shifted on its rising edge |
| ser_data | input | 1 | Serial bus data |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge loads the word |
| pwr_on | input | 1 | Hardware power-on pin |
| main_div | output | 17 | Main divider coefficient |
| ref_div | output | 11 | Reference divider coefficient |
| test_word | output | 17 | Test register contents |
| lock_det_en | output | 1 | Out-of-lock detector enable |
| cp_sel | output | 2 | Charge-pump current select code |
| cp_mult | output | 5 | Charge-pump current multiple selected by cp_sel |
| soft_pon | output | 1 | Software power-on bit |
| synth_on | output | 1 | Synthesizer power state |

## Verification
The assertions check four things on every core cycle: a shift and a load never happen in the same cycle, the shift register holds its value when no shift strobe is present, at most one holding register is written per load, and nothing changes on a load to an unused address. They also check that cp_mult always takes one of its four legal values. The bench covers the parts that depend on a whole frame. It sweeps all sixteen addresses and all four current codes, sends frames with extra leading bits, and toggles the serial clock while the enable is high and then re-loads the word with an empty frame. It also holds the enable low after the last bit to show that the load waits for the enable to rise.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

  localparam int DATA_W  = 17;
  localparam int ADDR_W  = 4;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int REF_W   = 11;
  localparam int MULT_W  = 5;

  // positions inside the data field of the control word
  localparam int CTL_LOCK_BIT = 12;
  localparam int CTL_CP_HI    = 10;
  localparam int CTL_CP_LO    = 9;
  localparam int CTL_PON_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TEST = 4'b0000,
    ADDR_CTRL = 4'b0001,
    ADDR_MAIN = 4'b0100,
    ADDR_REF  = 4'b0101
  } reg_addr_e;

  // one-hot write select index
  localparam int SEL_TEST = 0;
  localparam int SEL_CTRL = 1;
  localparam int SEL_MAIN = 2;
  localparam int SEL_REF  = 3;
  localparam int SEL_N    = 4;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] cp_sel;
    logic       soft_pon;
  } ctrl_t;

  function automatic logic [SEL_N-1:0] addr_decode(input logic [ADDR_W-1:0] a);
    logic [SEL_N-1:0] s;
    s = '0;
    case (a)
      ADDR_TEST: s[SEL_TEST] = 1'b1;
      ADDR_CTRL: s[SEL_CTRL] = 1'b1;
      ADDR_MAIN: s[SEL_MAIN] = 1'b1;
      ADDR_REF:  s[SEL_REF]  = 1'b1;
      default:   s = '0;
    endcase
    return s;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] d);
    ctrl_t c;
    c.lock_en  = d[CTL_LOCK_BIT];
    c.cp_sel   = d[CTL_CP_HI:CTL_CP_LO];
    c.soft_pon = d[CTL_PON_BIT];
    return c;
  endfunction

  function automatic logic [MULT_W-1:0] cp_multiple(input logic [1:0] code);
    logic [MULT_W-1:0] m;
    case (code)
      2'b00:   m = 5'd10;
      2'b01:   m = 5'd18;
      2'b10:   m = 5'd13;
      default: m = 5'd17;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tlw_bus_sync.sv
module tlw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_en_n,
  output logic shift_stb,
  output logic load_stb,
  output logic bit_val
);

  // lane order {en_n, data, clk}; enable idles high
  localparam int LANES = 3;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;
  localparam int L_EN  = 2;
  localparam logic [LANES-1:0] IDLE = 3'b100;

  logic [LANES-1:0] stage_q [STAGES];
  logic             clk_prev_q;
  logic             en_prev_q;
  logic [LANES-1:0] lanes_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE;
        else        stage_q[g] <= {ser_en_n, ser_data, ser_clk};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign lanes_s = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      en_prev_q  <= 1'b1;
    end else begin
      clk_prev_q <= lanes_s[L_CLK];
      en_prev_q  <= lanes_s[L_EN];
    end
  end

  assign shift_stb = lanes_s[L_CLK] & ~clk_prev_q & ~lanes_s[L_EN];
  assign load_stb  = lanes_s[L_EN] & ~en_prev_q;
  assign bit_val   = lanes_s[L_DAT];

  // R2 R10: shifting and loading are exclusive
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && load_stb));

endmodule

// File: rtl/tlw_shifter.sv
module tlw_shifter #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_stb,
  input  logic         bit_val,
  output logic [W-1:0] frame
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr_q <= '0;
    else if (shift_stb) sr_q <= {sr_q[W-2:0], bit_val};
  end

  assign frame = sr_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_stb |=> $stable(sr_q));

  // R3 R4: newest bit lands at the LSB, older bits move up
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> (sr_q[0] == $past(bit_val)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

endmodule

// File: rtl/tlw_regfile.sv
module tlw_regfile
  import tlw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [FRAME_W-1:0] frame,
  output logic [DATA_W-1:0] test_q,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] main_q,
  output logic [REF_W-1:0]  ref_q
);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [SEL_N-1:0]  hit;
  logic [SEL_N-1:0]  wr;

  assign addr = frame[ADDR_W-1:0];
  assign data = frame[FRAME_W-1:ADDR_W];
  assign hit  = addr_decode(addr);
  assign wr   = hit & {SEL_N{load_stb}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
      ctrl_q <= '0;
      main_q <= '0;
      ref_q  <= '0;
    end else begin
      if (wr[SEL_TEST]) test_q <= data;
      if (wr[SEL_CTRL]) ctrl_q <= ctrl_unpack(data);
      if (wr[SEL_MAIN]) main_q <= data;
      if (wr[SEL_REF])  ref_q  <= data[REF_W-1:0];
    end
  end

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr));

  // R9
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && (hit == '0)) |=>
      $stable(test_q) && $stable(ctrl_q) && $stable(main_q) && $stable(ref_q));

  // R10
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_stb |=>
      $stable(test_q) && $stable(ctrl_q) && $stable(main_q) && $stable(ref_q));

  // R4
  main_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && (addr == ADDR_MAIN)) |=> main_q == $past(frame[FRAME_W-1:ADDR_W]));

  // R5
  ref_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && (addr == ADDR_REF)) |=> ref_q == $past(frame[ADDR_W+REF_W-1:ADDR_W]));

endmodule

// File: rtl/tlw_loader.sv
module tlw_loader
  import tlw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_data,
  input  logic                ser_en_n,
  input  logic                pwr_on,
  output logic [DATA_W-1:0]   main_div,
  output logic [REF_W-1:0]    ref_div,
  output logic [DATA_W-1:0]   test_word,
  output logic                lock_det_en,
  output logic [1:0]          cp_sel,
  output logic [MULT_W-1:0]   cp_mult,
  output logic                soft_pon,
  output logic                synth_on
);

  logic               shift_stb;
  logic               load_stb;
  logic               bit_val;
  logic [FRAME_W-1:0] frame;
  ctrl_t              ctrl_q;

  tlw_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_en_n  (ser_en_n),
    .shift_stb (shift_stb),
    .load_stb  (load_stb),
    .bit_val   (bit_val)
  );

  tlw_shifter #(.W(FRAME_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_stb (shift_stb),
    .bit_val   (bit_val),
    .frame     (frame)
  );

  tlw_regfile i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .frame    (frame),
    .test_q   (test_word),
    .ctrl_q   (ctrl_q),
    .main_q   (main_div),
    .ref_q    (ref_div)
  );

  assign lock_det_en = ctrl_q.lock_en;
  assign cp_sel      = ctrl_q.cp_sel;
  assign soft_pon    = ctrl_q.soft_pon;
  assign cp_mult     = cp_multiple(ctrl_q.cp_sel);
  assign synth_on    = pwr_on & ctrl_q.soft_pon;

  // R7
  cp_mult_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mult == 5'd10) || (cp_mult == 5'd13) || (cp_mult == 5'd17) || (cp_mult == 5'd18));

  // R11
  power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synth_on |-> soft_pon);

endmodule

// File: tb/test_tlw_loader.sv
module test_tlw_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        pwr_on = 1'b0;
  logic [16:0] main_div;
  logic [10:0] ref_div;
  logic [16:0] test_word;
  logic        lock_det_en;
  logic [1:0]  cp_sel;
  logic [4:0]  cp_mult;
  logic        soft_pon;
  logic        synth_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [16:0] m_main, m_test;
  logic [10:0] m_ref;
  logic        m_lock, m_pon;
  logic [1:0]  m_cp;

  always #2.5 clk = ~clk;

  tlw_loader i_tlw_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en_n(ser_en_n), .pwr_on(pwr_on), .main_div(main_div), .ref_div(ref_div),
    .test_word(test_word), .lock_det_en(lock_det_en), .cp_sel(cp_sel),
    .cp_mult(cp_mult), .soft_pon(soft_pon), .synth_on(synth_on)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mult_of(input logic [1:0] c);
    int t[4] = '{10, 18, 13, 17};
    return t[c];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    ser_en_n = 1'b0;
    wait_cyc(4);
  endtask

  task automatic clock_bit(input logic b);
    ser_data = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
  endtask

  task automatic close_frame();
    wait_cyc(4);
    ser_en_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic shift_word(input logic [16:0] d, input logic [3:0] a);
    for (int i = 16; i >= 0; i--) clock_bit(d[i]);
    for (int i = 3; i >= 0; i--) clock_bit(a[i]);
  endtask

  task automatic model(input logic [16:0] d, input logic [3:0] a);
    case (a)
      4'b0000: m_test = d;
      4'b0001: begin m_lock = d[12]; m_cp = d[10:9]; m_pon = d[6]; end
      4'b0100: m_main = d;
      4'b0101: m_ref = d[10:0];
      default: ;
    endcase
  endtask

  task automatic send(input logic [16:0] d, input logic [3:0] a);
    open_frame();
    shift_word(d, a);
    close_frame();
    model(d, a);
  endtask

  task automatic check_all(input string req);
    chk(req, "main_div", int'(main_div), int'(m_main));
    chk(req, "ref_div", int'(ref_div), int'(m_ref));
    chk(req, "test_word", int'(test_word), int'(m_test));
    chk(req, "lock_det_en", int'(lock_det_en), int'(m_lock));
    chk(req, "cp_sel", int'(cp_sel), int'(m_cp));
    chk(req, "soft_pon", int'(soft_pon), int'(m_pon));
    chk(req, "cp_mult", int'(cp_mult), mult_of(m_cp));
    chk(req, "synth_on", int'(synth_on), int'(pwr_on & m_pon));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_main = '0; m_test = '0; m_ref = '0; m_lock = 0; m_pon = 0; m_cp = 0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1: reset state
    check_all("R1");
    chk("R1", "cp_mult reset", int'(cp_mult), 10);

    // R4 main divider, MSB first
    send(17'h1A5C3, 4'b0100);
    chk("R4", "main_div", int'(main_div), 'h1A5C3);
    check_all("R4");

    // R5 reference divider keeps low 11 bits
    send(17'h1FFFF, 4'b0101);
    chk("R5", "ref_div", int'(ref_div), 'h7FF);
    send(17'h0F2A5, 4'b0101);
    chk("R5", "ref_div", int'(ref_div), 'h2A5);

    // R8 test word
    send(17'h15555, 4'b0000);
    chk("R8", "test_word", int'(test_word), 'h15555);

    // R6 R7 control fields and all current codes
    for (int c = 0; c < 4; c++) begin
      logic [16:0] w;
      w = '0;
      w[12] = c[0];
      w[10:9] = c[1:0];
      w[6] = c[1];
      send(w, 4'b0001);
      chk("R6", "cp_sel", int'(cp_sel), c);
      chk("R6", "lock_det_en", int'(lock_det_en), c & 1);
      chk("R6", "soft_pon", int'(soft_pon), (c >> 1) & 1);
      chk("R7", "cp_mult", int'(cp_mult), mult_of(c[1:0]));
    end
    // R6 neighbouring bits do not leak into fields
    send(17'h1E9BF & ~17'h01640, 4'b0001);
    chk("R6", "neighbour bits", int'({lock_det_en, cp_sel, soft_pon}), 0);

    // R9 sweep of all 16 addresses
    for (int a = 0; a < 16; a++) begin
      logic [16:0] w;
      w = 17'(((a * 7919) ^ 17'h0B6D3) + a);
      send(w, a[3:0]);
      check_all("R9");
    end

    // R3 extra leading bits are discarded
    open_frame();
    for (int i = 0; i < 5; i++) clock_bit(1'b1);
    shift_word(17'h00321, 4'b0100);
    close_frame();
    model(17'h00321, 4'b0100);
    chk("R3", "main_div after 26 bits", int'(main_div), 'h00321);
    check_all("R3");

    // R10 no load while enable still low
    open_frame();
    shift_word(17'h0ABCD, 4'b0100);
    wait_cyc(20);
    chk("R10", "main_div before enable rise", int'(main_div), 'h00321);
    close_frame();
    model(17'h0ABCD, 4'b0100);
    chk("R10", "main_div after enable rise", int'(main_div), 'h0ABCD);

    // R2 clocks with enable high are ignored, checked via empty re-load
    send(17'h00040, 4'b0001);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] p;
      p = 4'b0100;
      clock_bit(p[3 - i]);
    end
    wait_cyc(8);
    open_frame();
    close_frame();
    check_all("R2");
    chk("R2", "main_div untouched", int'(main_div), 'h0ABCD);

    // R11 loading while powered down and power gating
    pwr_on = 1'b0;
    send(17'h00000, 4'b0001);
    send(17'h00040, 4'b0001);
    chk("R11", "soft_pon loads while off", int'(soft_pon), 1);
    chk("R11", "synth_on pin low", int'(synth_on), 0);
    send(17'h1357, 4'b0100);
    chk("R11", "main loads while off", int'(main_div), 'h1357);
    pwr_on = 1'b1;
    wait_cyc(1);
    chk("R11", "synth_on both high", int'(synth_on), 1);
    send(17'h00000, 4'b0001);
    chk("R11", "synth_on soft bit low", int'(synth_on), 0);
    check_all("R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule